// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Condition Flags

This block is the integer division unit of a processor execution pipeline. The issue stage hands it the operands together with the destination register indices on a one-cycle start strobe. The block then runs a restoring division and, on a one-cycle done strobe, returns the data to write back, separate write enables for the quotient and remainder registers, and the four arithmetic condition flags (negative, zero, overflow, carry). A zero divisor skips the arithmetic. It is reported as a divide-by-zero exception, and nothing is written.

Three operand sizes are supported, each in a signed and an unsigned variant:
- **Word form.** A full-width dividend is divided by a half-width divisor. The half-width remainder and the half-width quotient are packed into one register.
- **Single-width long form.** Divides one full-width register by another.
- **Double-width long form.** The dividend is the concatenation of the two destination registers.

When a quotient does not fit, the block reports overflow and leaves every register untouched. The register file itself stays outside the block.

Top module: `idiv_flags_unit`

## Requirements
- R1: A zero divisor ends the operation with dz_o high alongside done_o, and quo_we_o, rem_we_o and flag_we_o all low. The divisor is bits 15:0 of divisor_i for the word form and all 32 bits for the other forms.
- R2: Every operation with a non-zero divisor completes with flag_we_o high and flag_c_o low, including when it overflows.
- R3: Word form (size_i = 2'b00) overflows when the unsigned quotient exceeds 0xFFFF, or when the signed quotient lies outside -32768..32767. On overflow: flag_v_o=1, flag_z_o=0, flag_n_o equals n_in_i as sampled with start, and both write enables are low.
- R4: A word form without overflow drives quo_we_o high and rem_we_o low, with quo_data_o = {remainder[15:0], quotient[15:0]}. It sets flag_n_o from quotient bit 15, sets flag_z_o when quotient[15:0] is zero, and clears flag_v_o.
- R5: The single-width long form (size_i = 2'b01, and also the code 2'b11) divides quo_val_i and never reports overflow. quo_data_o is the low 32 bits of the exact quotient. flag_n_o is quotient bit 31, flag_z_o is set when that quotient is zero, and flag_v_o is 0.
- R6: The double-width form (size_i = 2'b10) divides {rem_val_i, quo_val_i} (upper half first). It overflows when the quotient is outside 0..2^32-1 (unsigned) or -2^31..2^31-1 (signed), and then behaves as in R3.
- R7: A long form without overflow writes the quotient to quo_idx_o and the remainder to rem_idx_o. When the two indices are equal, only quo_we_o is raised.
- R8: With signed_i high, the quotient is truncated toward zero and the remainder takes the sign of the dividend. The word-form divisor is then bits 15:0 of divisor_i, sign-extended.
- R9: done_o is high for one cycle. Counting the cycle that accepts start as cycle 0, done_o appears in cycle 33 for the word and single-width forms, in cycle 65 for the double-width form, and in cycle 1 for a zero divisor.
- R10: start_i is accepted only while busy_o is low. A start raised during a division changes neither that division's result nor its timing.
- R11: After reset, done_o, busy_o and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; operands are sampled with it |
| size_i | input | 2 | 00 word, 01 single-width long, 10 double-width long, 11 as 01 |
| signed_i | input | 1 | Signed division when high |
| quo_idx_i | input | IDX_W | Quotient (and word destination) register index |
| rem_idx_i | input | IDX_W | Remainder register index |
| quo_val_i | input | WORD_W | Contents of the quotient register (dividend, or its low half) |
| rem_val_i | input | WORD_W | Contents of the remainder register (upper dividend half, double-width form) |
| divisor_i | input | WORD_W | Divisor |
| n_in_i | input | 1 | Current N flag, kept on overflow |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | Result strobe, one cycle |
| dz_o | output | 1 | Divide-by-zero exception, valid with done_o |
| quo_we_o | output | 1 | Write enable for the quotient register |
| rem_we_o | output | 1 | Write enable for the remainder register |
| quo_idx_o | output | IDX_W | Quotient register index of the finishing operation |
| rem_idx_o | output | IDX_W | Remainder register index of the finishing operation |
| quo_data_o | output | WORD_W | Data for the quotient register |
| rem_data_o | output | WORD_W | Data for the remainder register |
| flag_we_o | output | 1 | Flag update enable |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The bench builds the block with its defaults, WORD_W = 32 and IDX_W = 3. These defaults give a 64-bit double-width dividend, a 16-bit word divisor and eight register indices. Random index pairs therefore coincide often enough to exercise the single-write rule. The 32-bit extremes put the corner cases within reach: the most negative dividend divided by minus one, quotients of exactly 2^31 and 2^32, and word quotients one past 16 bits. The bench predicts each result with 66-bit signed arithmetic, so the reference model itself can never overflow.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

   // Operand size selector; the reserved code divides as the single-width form.
   typedef enum logic [1:0] {
      DIV_WORD = 2'b00,
      DIV_LONG = 2'b01,
      DIV_WIDE = 2'b10,
      DIV_RSVD = 2'b11
   } div_size_e;

endpackage

// File: rtl/idiv_operand_prep.sv
module idiv_operand_prep
   import idiv_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int HALF_W = WORD_W / 2,
   localparam int DBL_W  = 2 * WORD_W,
   localparam int CNT_W  = $clog2(DBL_W + 1)
) (
   input  div_size_e           size_i,
   input  logic                sgn_i,
   input  logic [WORD_W-1:0]   lo_i,
   input  logic [WORD_W-1:0]   hi_i,
   input  logic [WORD_W-1:0]   dvs_i,
   output logic [DBL_W-1:0]    dvd_mag_o,
   output logic [WORD_W-1:0]   dvs_mag_o,
   output logic [CNT_W-1:0]    steps_o,
   output logic                quo_neg_o,
   output logic                rem_neg_o,
   output logic                dz_o
);

   localparam logic [CNT_W-1:0] STEPS_SHORT = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] STEPS_LONG  = CNT_W'(DBL_W);

   logic              is_wide, is_word;
   logic [DBL_W-1:0]  dvd_full, dvd_abs;
   logic [WORD_W-1:0] dvs_full;
   logic              dvd_neg, dvs_neg;

   assign is_wide = (size_i == DIV_WIDE);
   assign is_word = (size_i == DIV_WORD);

   always_comb begin
      if (is_wide) dvd_full = {hi_i, lo_i};
      else         dvd_full = {{WORD_W{sgn_i & lo_i[WORD_W-1]}}, lo_i};
      if (is_word) dvs_full = {{HALF_W{sgn_i & dvs_i[HALF_W-1]}}, dvs_i[HALF_W-1:0]};
      else         dvs_full = dvs_i;
   end

   assign dvd_neg   = sgn_i & dvd_full[DBL_W-1];
   assign dvs_neg   = sgn_i & dvs_full[WORD_W-1];
   assign dvd_abs   = dvd_neg ? (~dvd_full + 1'b1) : dvd_full;
   assign dvs_mag_o = dvs_neg ? (~dvs_full + 1'b1) : dvs_full;

   // Short forms are left-aligned so the quotient lands in the low half.
   assign dvd_mag_o = is_wide ? dvd_abs : {dvd_abs[WORD_W-1:0], {WORD_W{1'b0}}};
   assign steps_o   = is_wide ? STEPS_LONG : STEPS_SHORT;
   assign quo_neg_o = dvd_neg ^ dvs_neg;
   assign rem_neg_o = dvd_neg;
   assign dz_o      = (dvs_full == '0);

endmodule

// File: rtl/idiv_restoring_core.sv
module idiv_restoring_core #(
   parameter int WORD_W = 32,
   localparam int DBL_W = 2 * WORD_W,
   localparam int CNT_W = $clog2(DBL_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [DBL_W-1:0]   dvd_i,
   input  logic [WORD_W-1:0]  dvs_i,
   input  logic [CNT_W-1:0]   steps_i,
   output logic               busy_o,
   output logic               fin_o,
   output logic [DBL_W-1:0]   quo_o,
   output logic [WORD_W-1:0]  rem_o
);

   logic [WORD_W-1:0] acc_q, dvs_q;
   logic [DBL_W-1:0]  dq_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W:0]   shifted, trial;
   logic              take;

   // One restoring step: shift in the next dividend bit, try the subtraction.
   assign shifted = {acc_q, dq_q[DBL_W-1]};
   assign trial   = shifted - {1'b0, dvs_q};
   assign take    = ~trial[WORD_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         dvs_q  <= '0;
         dq_q   <= '0;
         cnt_q  <= '0;
         busy_o <= 1'b0;
         fin_o  <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (load_i) begin
            acc_q  <= '0;
            dq_q   <= dvd_i;
            dvs_q  <= dvs_i;
            cnt_q  <= steps_i;
            busy_o <= 1'b1;
         end else if (busy_o) begin
            acc_q <= take ? trial[WORD_W-1:0] : shifted[WORD_W-1:0];
            dq_q  <= {dq_q[DBL_W-2:0], take};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy_o <= 1'b0;
               fin_o  <= 1'b1;
            end
         end
      end
   end

   assign quo_o = dq_q;
   assign rem_o = acc_q;

endmodule

// File: rtl/idiv_result_fix.sv
module idiv_result_fix
   import idiv_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int HALF_W = WORD_W / 2,
   localparam int DBL_W  = 2 * WORD_W
) (
   input  div_size_e          size_i,
   input  logic               sgn_i,
   input  logic               quo_neg_i,
   input  logic               rem_neg_i,
   input  logic [DBL_W-1:0]   quo_mag_i,
   input  logic [WORD_W-1:0]  rem_mag_i,
   input  logic               n_keep_i,
   output logic               ovf_o,
   output logic [WORD_W-1:0]  quo_word_o,
   output logic [WORD_W-1:0]  rem_word_o,
   output logic               n_o,
   output logic               z_o
);

   localparam logic [DBL_W-1:0] NEG_LIM_H = DBL_W'(1) << (HALF_W - 1);
   localparam logic [DBL_W-1:0] NEG_LIM_W = DBL_W'(1) << (WORD_W - 1);

   logic [DBL_W-1:0]  quo_s;
   logic [WORD_W-1:0] rem_s;
   logic              fit_h, fit_w, is_word;

   assign quo_s   = quo_neg_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
   assign rem_s   = rem_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
   assign is_word = (size_i == DIV_WORD);

   // Range checks are made on the magnitude before the sign is applied.
   always_comb begin
      if (!sgn_i)         fit_h = (quo_mag_i[DBL_W-1:HALF_W] == '0);
      else if (quo_neg_i) fit_h = (quo_mag_i <= NEG_LIM_H);
      else                fit_h = (quo_mag_i[DBL_W-1:HALF_W-1] == '0);
      if (!sgn_i)         fit_w = (quo_mag_i[DBL_W-1:WORD_W] == '0);
      else if (quo_neg_i) fit_w = (quo_mag_i <= NEG_LIM_W);
      else                fit_w = (quo_mag_i[DBL_W-1:WORD_W-1] == '0);
   end

   always_comb begin
      case (size_i)
         DIV_WORD: ovf_o = ~fit_h;
         DIV_WIDE: ovf_o = ~fit_w;
         default:  ovf_o = 1'b0;
      endcase
   end

   assign quo_word_o = is_word ? {rem_s[HALF_W-1:0], quo_s[HALF_W-1:0]} : quo_s[WORD_W-1:0];
   assign rem_word_o = rem_s;

   always_comb begin
      if (ovf_o) begin
         n_o = n_keep_i;
         z_o = 1'b0;
      end else if (is_word) begin
         n_o = quo_s[HALF_W-1];
         z_o = (quo_s[HALF_W-1:0] == '0);
      end else begin
         n_o = quo_s[WORD_W-1];
         z_o = (quo_s[WORD_W-1:0] == '0);
      end
   end

endmodule

// File: rtl/idiv_flags_unit.sv
module idiv_flags_unit
   import idiv_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [1:0]         size_i,
   input  logic               signed_i,
   input  logic [IDX_W-1:0]   quo_idx_i,
   input  logic [IDX_W-1:0]   rem_idx_i,
   input  logic [WORD_W-1:0]  quo_val_i,
   input  logic [WORD_W-1:0]  rem_val_i,
   input  logic [WORD_W-1:0]  divisor_i,
   input  logic               n_in_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               dz_o,
   output logic               quo_we_o,
   output logic               rem_we_o,
   output logic [IDX_W-1:0]   quo_idx_o,
   output logic [IDX_W-1:0]   rem_idx_o,
   output logic [WORD_W-1:0]  quo_data_o,
   output logic [WORD_W-1:0]  rem_data_o,
   output logic               flag_we_o,
   output logic               flag_n_o,
   output logic               flag_z_o,
   output logic               flag_v_o,
   output logic               flag_c_o
);

   localparam int DBL_W = 2 * WORD_W;
   localparam int CNT_W = $clog2(DBL_W + 1);

   generate
      if (WORD_W < 8 || (WORD_W % 2) != 0) begin : g_bad_width
         $error("idiv_flags_unit: WORD_W must be even and at least 8");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("idiv_flags_unit: IDX_W must be at least 1");
      end
   endgenerate

   div_size_e         size_in, size_q;
   logic              accept, load_core;
   logic [DBL_W-1:0]  dvd_mag, quo_mag;
   logic [WORD_W-1:0] dvs_mag, rem_mag;
   logic [CNT_W-1:0]  steps;
   logic              quo_neg_in, rem_neg_in, dz_in;
   logic              sgn_q, quo_neg_q, rem_neg_q, n_keep_q, dz_done_q;
   logic              core_busy, core_fin, ovf, fix_n, fix_z;
   logic [WORD_W-1:0] fix_quo, fix_rem;

   assign size_in   = div_size_e'(size_i);
   assign accept    = start_i & ~core_busy;
   assign load_core = accept & ~dz_in;

   idiv_operand_prep #(.WORD_W(WORD_W)) u_prep (
      .size_i    (size_in),
      .sgn_i     (signed_i),
      .lo_i      (quo_val_i),
      .hi_i      (rem_val_i),
      .dvs_i     (divisor_i),
      .dvd_mag_o (dvd_mag),
      .dvs_mag_o (dvs_mag),
      .steps_o   (steps),
      .quo_neg_o (quo_neg_in),
      .rem_neg_o (rem_neg_in),
      .dz_o      (dz_in)
   );

   idiv_restoring_core #(.WORD_W(WORD_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_core),
      .dvd_i   (dvd_mag),
      .dvs_i   (dvs_mag),
      .steps_i (steps),
      .busy_o  (core_busy),
      .fin_o   (core_fin),
      .quo_o   (quo_mag),
      .rem_o   (rem_mag)
   );

   // Operation context captured on acceptance, used when the result retires.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q    <= DIV_WORD;
         sgn_q     <= 1'b0;
         quo_neg_q <= 1'b0;
         rem_neg_q <= 1'b0;
         n_keep_q  <= 1'b0;
         quo_idx_o <= '0;
         rem_idx_o <= '0;
         dz_done_q <= 1'b0;
      end else begin
         dz_done_q <= accept & dz_in;
         if (accept) begin
            size_q    <= size_in;
            sgn_q     <= signed_i;
            quo_neg_q <= quo_neg_in;
            rem_neg_q <= rem_neg_in;
            n_keep_q  <= n_in_i;
            quo_idx_o <= quo_idx_i;
            rem_idx_o <= rem_idx_i;
         end
      end
   end

   idiv_result_fix #(.WORD_W(WORD_W)) u_fix (
      .size_i     (size_q),
      .sgn_i      (sgn_q),
      .quo_neg_i  (quo_neg_q),
      .rem_neg_i  (rem_neg_q),
      .quo_mag_i  (quo_mag),
      .rem_mag_i  (rem_mag),
      .n_keep_i   (n_keep_q),
      .ovf_o      (ovf),
      .quo_word_o (fix_quo),
      .rem_word_o (fix_rem),
      .n_o        (fix_n),
      .z_o        (fix_z)
   );

   assign busy_o     = core_busy;
   assign done_o     = core_fin | dz_done_q;
   assign dz_o       = dz_done_q;
   assign quo_we_o   = core_fin & ~ovf;
   assign rem_we_o   = core_fin & ~ovf & (size_q != DIV_WORD) & (quo_idx_o != rem_idx_o);
   assign quo_data_o = fix_quo;
   assign rem_data_o = fix_rem;
   assign flag_we_o  = core_fin;
   assign flag_n_o   = fix_n;
   assign flag_z_o   = fix_z;
   assign flag_v_o   = core_fin & ovf;
   assign flag_c_o   = 1'b0;

endmodule

// File: rtl/idiv_flags_unit_chk.sv
module idiv_flags_unit_chk
   import idiv_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int IDX_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic [1:0]         size_i,
   input logic [WORD_W-1:0]  divisor_i,
   input logic               n_in_i,
   input logic               busy_o,
   input logic               done_o,
   input logic               dz_o,
   input logic               quo_we_o,
   input logic               rem_we_o,
   input logic [IDX_W-1:0]   quo_idx_o,
   input logic [IDX_W-1:0]   rem_idx_o,
   input logic               flag_we_o,
   input logic               flag_n_o,
   input logic               flag_z_o,
   input logic               flag_v_o,
   input logic               flag_c_o
);

   localparam int HALF_W = WORD_W / 2;
   localparam int LAT_W  = $clog2(2 * WORD_W + 2) + 1;

   logic             acc, acc_dz;
   logic             cap_n, cap_dz;
   logic [1:0]       cap_size;
   logic [LAT_W-1:0] lat, cap_exp;

   assign acc    = start_i & ~busy_o;
   assign acc_dz = (size_i == DIV_WORD) ? (divisor_i[HALF_W-1:0] == '0) : (divisor_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_n    <= 1'b0;
         cap_dz   <= 1'b0;
         cap_size <= 2'b00;
         cap_exp  <= '0;
         lat      <= '0;
      end else if (acc) begin
         cap_n    <= n_in_i;
         cap_dz   <= acc_dz;
         cap_size <= size_i;
         cap_exp  <= acc_dz ? LAT_W'(0) :
                     (size_i == DIV_WIDE) ? LAT_W'(2 * WORD_W) : LAT_W'(WORD_W);
         lat      <= '0;
      end else if (lat != '1) begin
         lat <= lat + 1'b1;
      end
   end

   a_r1_dz_silent: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && dz_o |-> !quo_we_o && !rem_we_o && !flag_we_o);
   a_r1_dz_match: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> dz_o == cap_dz);
   a_r2_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !dz_o |-> flag_we_o && !flag_c_o);
   a_r3_ovf_shape: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && flag_v_o |-> !quo_we_o && !rem_we_o && !flag_z_o && (flag_n_o == cap_n));
   a_r4_word_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && cap_size == DIV_WORD |-> !rem_we_o);
   a_r5_long_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !dz_o && (cap_size == DIV_LONG || cap_size == DIV_RSVD) |-> !flag_v_o && quo_we_o);
   a_r7_same_idx: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && rem_we_o |-> quo_we_o && (quo_idx_o != rem_idx_o));
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> lat == cap_exp);
   a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

endmodule

bind idiv_flags_unit idiv_flags_unit_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .size_i    (size_i),
   .divisor_i (divisor_i),
   .n_in_i    (n_in_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .dz_o      (dz_o),
   .quo_we_o  (quo_we_o),
   .rem_we_o  (rem_we_o),
   .quo_idx_o (quo_idx_o),
   .rem_idx_o (rem_idx_o),
   .flag_we_o (flag_we_o),
   .flag_n_o  (flag_n_o),
   .flag_z_o  (flag_z_o),
   .flag_v_o  (flag_v_o),
   .flag_c_o  (flag_c_o)
);

// File: tb/tb_idiv_flags_unit.sv
module tb_idiv_flags_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  size_i = 2'b00;
   logic        signed_i = 1'b0;
   logic [2:0]  quo_idx_i = '0, rem_idx_i = '0;
   logic [31:0] quo_val_i = '0, rem_val_i = '0, divisor_i = '0;
   logic        n_in_i = 1'b0;
   logic        busy_o, done_o, dz_o, quo_we_o, rem_we_o, flag_we_o;
   logic [2:0]  quo_idx_o, rem_idx_o;
   logic [31:0] quo_data_o, rem_data_o;
   logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;  // 125 MHz

   idiv_flags_unit #(.WORD_W(32), .IDX_W(3)) dut (.*);

   typedef struct {
      bit        dz, qwe, rwe, fwe, n, z, v;
      bit [31:0] qd, rd;
      bit [2:0]  qi, ri;
      int        lat;
   } exp_t;

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Reference computed with 66-bit signed arithmetic (R8 truncation rules).
   function automatic exp_t model(input bit [1:0] sz, input bit sg, input bit [31:0] qv, rv, dv,
                                  input bit nin, input bit [2:0] qi, ri);
      exp_t e;
      logic signed [65:0] a, b, q, r;
      bit ovf;
      e = '{default: 0};
      e.qi = qi; e.ri = ri;
      if (sz == 2'b00) begin
         if (sg) b = $signed(dv[15:0]); else b = {50'b0, dv[15:0]};
      end else begin
         if (sg) b = $signed(dv); else b = {34'b0, dv};
      end
      if (sz == 2'b10) begin
         if (sg) a = $signed({rv, qv}); else a = {2'b0, rv, qv};
      end else begin
         if (sg) a = $signed(qv); else a = {34'b0, qv};
      end
      if (b == 0) begin
         e.dz = 1; e.lat = 1;
         return e;
      end
      q = a / b;
      r = a % b;
      e.fwe = 1;
      e.lat = (sz == 2'b10) ? 65 : 33;
      case (sz)
         2'b00:   ovf = sg ? (q > 66'sd32767 || q < -66'sd32768) : (q > 66'sd65535);
         2'b10:   ovf = sg ? (q > 66'sd2147483647 || q < -66'sd2147483648) : (q > 66'sd4294967295);
         default: ovf = 0;
      endcase
      if (ovf) begin
         e.v = 1; e.n = nin; e.z = 0;
      end else if (sz == 2'b00) begin
         e.qwe = 1; e.qd = {r[15:0], q[15:0]};
         e.n = q[15]; e.z = (q[15:0] == 0);
      end else begin
         e.qwe = 1; e.qd = q[31:0];
         e.rwe = (qi != ri); e.rd = r[31:0];
         e.n = q[31]; e.z = (q[31:0] == 0);
      end
      return e;
   endfunction

   task automatic compare(input string tag, input exp_t e, input int cyc);
      check({tag, " R9"}, "latency", cyc, e.lat);
      check({tag, " R1"}, "dz", dz_o, e.dz);
      check({tag, " R2"}, "flag_we", flag_we_o, e.fwe);
      check({tag, " R7"}, "quo_we", quo_we_o, e.qwe);
      check({tag, " R7"}, "rem_we", rem_we_o, e.rwe);
      if (e.qwe) check({tag, " R8"}, "quo_data", quo_data_o, e.qd);
      if (e.qwe) check({tag, " R7"}, "quo_idx", quo_idx_o, e.qi);
      if (e.rwe) check({tag, " R8"}, "rem_data", rem_data_o, e.rd);
      if (e.rwe) check({tag, " R7"}, "rem_idx", rem_idx_o, e.ri);
      if (e.fwe) begin
         check({tag, " R3"}, "flag_v", flag_v_o, e.v);
         check({tag, " R3"}, "flag_n", flag_n_o, e.n);
         check({tag, " R3"}, "flag_z", flag_z_o, e.z);
         check({tag, " R2"}, "flag_c", flag_c_o, 1'b0);
      end
   endtask

   task automatic run_op(input string tag, input bit [1:0] sz, input bit sg,
                         input bit [31:0] qv, rv, dv, input bit nin, input bit [2:0] qi, ri);
      exp_t e;
      int cyc;
      e = model(sz, sg, qv, rv, dv, nin, qi, ri);
      @(negedge clk);
      size_i = sz; signed_i = sg; quo_val_i = qv; rem_val_i = rv; divisor_i = dv;
      n_in_i = nin; quo_idx_i = qi; rem_idx_i = ri; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cyc = 1;
      while (!done_o && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      compare(tag, e, cyc);
      @(negedge clk);
      check({tag, " R9"}, "done one cycle", done_o, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      exp_t e;
      int cyc;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11", "done", done_o, 1'b0);
      check("R11", "busy", busy_o, 1'b0);
      check("R11", "quo_we", quo_we_o, 1'b0);
      check("R11", "rem_we", rem_we_o, 1'b0);
      rst_n = 1'b1;

      run_op("R4 word unsigned",        2'b00, 0, 32'd100,       0, 32'd7,          0, 3'd1, 3'd2);
      run_op("R3 word unsigned ovf",    2'b00, 0, 32'h0010_0000, 0, 32'd1,          1, 3'd1, 3'd2);
      run_op("R3 word 0xFFFF edge",     2'b00, 0, 32'h0001_FFFE, 0, 32'd2,          0, 3'd1, 3'd2);
      run_op("R8 word signed",          2'b00, 1, 32'hFFFF_FFF9, 0, 32'hABCD_0002,  0, 3'd4, 3'd4);
      run_op("R3 word signed min/-1",   2'b00, 1, 32'h8000_0000, 0, 32'h0000_FFFF,  0, 3'd0, 3'd5);
      run_op("R3 word signed -32768",   2'b00, 1, 32'hFFFF_0000, 0, 32'h0000_0002,  1, 3'd0, 3'd5);
      run_op("R1 word zero low half",   2'b00, 0, 32'd55,        0, 32'h0001_0000,  0, 3'd2, 3'd3);
      run_op("R1 long zero",            2'b01, 1, 32'd55,        0, 32'd0,          1, 3'd2, 3'd3);
      run_op("R5 long min/-1",          2'b01, 1, 32'h8000_0000, 0, 32'hFFFF_FFFF,  0, 3'd2, 3'd3);
      run_op("R5 reserved code",        2'b11, 0, 32'd1000,      0, 32'd33,         0, 3'd6, 3'd7);
      run_op("R7 long same index",      2'b01, 1, 32'hFFFF_FF9C, 0, 32'd7,          0, 3'd5, 3'd5);
      run_op("R5 zero quotient",        2'b01, 0, 32'd3,         0, 32'd9,          1, 3'd1, 3'd0);
      run_op("R6 wide 2^31 unsigned",   2'b10, 0, 32'd0,         32'd1, 32'd2,      0, 3'd1, 3'd2);
      run_op("R6 wide 2^32 ovf",        2'b10, 0, 32'd0,         32'd2, 32'd2,      1, 3'd1, 3'd2);
      run_op("R6 wide signed -2^31",    2'b10, 1, 32'd0,         32'hFFFF_FFFF, 32'd2, 0, 3'd3, 3'd1);
      run_op("R6 wide signed +2^31",    2'b10, 1, 32'd0,         32'd1, 32'd2,      0, 3'd3, 3'd1);
      run_op("R6 wide same index",      2'b10, 0, 32'h1234_5678, 32'd3, 32'd1000,   0, 3'd2, 3'd2);

      // R10: a start during a division is ignored
      e = model(2'b01, 0, 32'd999_999, 0, 32'd13, 0, 3'd1, 3'd2);
      @(negedge clk);
      size_i = 2'b01; signed_i = 0; quo_val_i = 32'd999_999; divisor_i = 32'd13;
      n_in_i = 0; quo_idx_i = 3'd1; rem_idx_i = 3'd2; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; cyc = 1;
      repeat (4) begin @(negedge clk); cyc++; end
      check("R10", "busy during run", busy_o, 1'b1);
      size_i = 2'b00; divisor_i = 32'd0; quo_val_i = 32'd5; quo_idx_i = 3'd7; start_i = 1'b1;
      @(negedge clk);
      cyc++; start_i = 1'b0;
      while (!done_o && cyc < 100) begin @(negedge clk); cyc++; end
      compare("R10 busy start ignored", e, cyc);
      @(negedge clk);
      check("R10", "no extra done", done_o, 1'b0);

      // Constrained random mix
      for (int i = 0; i < 300; i++) begin
         bit [1:0] sz;
         bit sg, nin;
         bit [31:0] qv, rv, dv;
         bit [2:0] qi, ri;
         sz = 2'($urandom % 4); sg = 1'($urandom); nin = 1'($urandom);
         qv = $urandom; rv = $urandom; dv = $urandom;
         if ($urandom % 3 == 0) qv = qv >> ($urandom % 32);
         if ($urandom % 4 == 0) dv = dv >> ($urandom % 32);
         if ($urandom % 2 == 0) rv = (sg && qv[31]) ? 32'hFFFF_FFFF : 32'd0;
         if ($urandom % 16 == 0) dv = 32'd0;
         qi = 3'($urandom); ri = 3'($urandom);
         if ($urandom % 6 == 0) ri = qi;
         run_op("R8 random", sz, sg, qv, rv, dv, nin, qi, ri);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule